// File: doc/BRIEF.md
# JTAG Debug Port Scan Interface

This block is a JTAG test access port that converts scans of a 35-bit access data register into transactions on an internal register bus toward access ports. A debugger loads one of three useful instructions into a 4-bit instruction register: one for debug-port register access, one for access-port register access, and one that exposes a 32-bit identification code. Any other code makes the data path a single-bit bypass. TCK clocks the whole block, so the internal bus is synchronous to TCK and TRST_N resets it asynchronously.

Each access scan carries a request and a result. The request sits in the bits shifted in: read flag, 2-bit register address and 32-bit write data. It takes effect on Update-DR. The result sits in the bits shifted out: the read data produced by the previous read and a fixed OK acknowledge. Access-port requests leave the block with an access-port number and bank taken from an internal select register. Debug-port requests are handled inside the block and touch that select register or a read buffer.

TAP controller states (all 16 are implemented): Test-Logic-Reset, Run-Test/Idle, Select-DR-Scan, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR, Update-DR, Select-IR-Scan, Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR, Update-IR. The transitions follow the standard TMS-driven graph. TMS=1 moves Test-Logic-Reset→itself, Run-Test/Idle→Select-DR, Select-DR→Select-IR, Select-IR→Test-Logic-Reset, Capture/Shift→Exit1, Exit1→Update, Pause→Exit2, Exit2→Update, and Update→Select-DR. TMS=0 moves Test-Logic-Reset→Run-Test/Idle, Run-Test/Idle→itself, Select-DR→Capture-DR, Select-IR→Capture-IR, Capture→Shift, Shift→itself, Exit1→Pause, Pause→itself, Exit2→Shift, and Update→Run-Test/Idle.

Top module: `jtag_dp_scan`

## Requirements
- R1: Five consecutive TCK edges with TMS high put the controller in Test-Logic-Reset from any state. Entering that state, or asserting TRST_N low, selects the identification instruction.
- R2: The instruction register is 4 bits, shifted LSB first. Capture-IR loads 4'b0001. Codes 4'hA (debug-port access), 4'hB (access-port access), 4'hE (identification) and 4'hF (bypass) are decoded. Every other code behaves as bypass.
- R3: Under the identification instruction, a 32-bit DR scan returns IDCODE_VAL LSB first, and its bits 11:0 equal 12'h477.
- R4: Under bypass, the data path is one stage that captures 0, so TDO repeats TDI one TCK later.
- R5: Under either access instruction the DR is 35 bits: bit 0 is the read flag (1 = read), bits 2:1 the register address, bits 34:3 the data. Capture-DR loads the acknowledge 3'b010 (OK) into bits 2:0.
- R6: An access-port scan issues, on the Update-DR edge, a request pulse that is high for exactly one TCK. It carries the scanned address, read flag and write data, with the port number and bank from the select register.
- R7: The data returned by a read appears in bits 34:3 of the next access scan, not the scan that issued it.
- R8: Debug-port address 2 is the select register. A write stores all 32 bits, with bits 31:24 giving the port number and bits 7:4 the bank. A read returns the stored value. Debug-port scans issue no bus request.
- R9: A read of debug-port address 3 returns the data of the latest access-port read response without issuing a bus request, even after other scans have replaced the return value.
- R10: A write, to either port type, leaves the data returned by the next scan unchanged. Reads of debug-port addresses 0 and 1 return zero.
- R11: TDO is 0 in every state other than Shift-DR and Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, also clocks the internal bus |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| req_valid | output | 1 | One-cycle access-port request strobe |
| req_addr | output | 2 | Access-port register address |
| req_rnw | output | 1 | 1 = read request, 0 = write |
| req_wdata | output | 32 | Write data |
| req_apsel | output | 8 | Access-port number from the select register |
| req_bank | output | 4 | Register bank from the select register |
| rsp_valid | input | 1 | Read response strobe |
| rsp_rdata | input | 32 | Read response data |

## Verification
The hardest case to reach is the read buffer returning access-port data after that data has left the return path. That happens when a debug-port read has since overwritten the value the next scan shifts out. The stimulus interleaves access-port reads and writes with debug-port reads of addresses 0, 1, 2 and 3 across instruction changes. It then checks every returned word one scan after its request. It also checks that the select register written earlier steers the port number and bank of later bus requests.

// File: rtl/jdp_pkg.sv
package jdp_pkg;

    localparam int DATA_W    = 32;
    localparam int IR_W      = 4;
    localparam int ACK_W     = 3;
    localparam int DR_W      = DATA_W + ACK_W;
    localparam int ADDR_W    = 2;
    localparam int APSEL_W   = 8;
    localparam int BANK_W    = 4;
    localparam int APSEL_LSB = 24;
    localparam int BANK_LSB  = 4;

    localparam logic [IR_W-1:0]   INS_DPACC  = 4'hA;
    localparam logic [IR_W-1:0]   INS_APACC  = 4'hB;
    localparam logic [IR_W-1:0]   INS_IDCODE = 4'hE;
    localparam logic [IR_W-1:0]   IR_CAPTURE = 4'b0001;
    localparam logic [ACK_W-1:0]  ACK_OK     = 3'b010;
    localparam logic [ADDR_W-1:0] DPA_SELECT = 2'd2;
    localparam logic [ADDR_W-1:0] DPA_RDBUF  = 2'd3;

    typedef enum logic [3:0] {
        S_RESET, S_IDLE,
        S_SEL_DR, S_CAP_DR, S_SHF_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
        S_SEL_IR, S_CAP_IR, S_SHF_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {K_BYPASS, K_IDCODE, K_ACCESS} dr_kind_e;

endpackage

// File: rtl/jdp_tap_fsm.sv
module jdp_tap_fsm
    import jdp_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       in_reset,
    output logic       cap_dr,
    output logic       shf_dr,
    output logic       upd_dr,
    output logic       cap_ir,
    output logic       shf_ir,
    output logic       upd_ir
);

    tap_state_e state_q, state_d;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= S_RESET;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RESET:  state_d = tms ? S_RESET  : S_IDLE;
            S_IDLE:   state_d = tms ? S_SEL_DR : S_IDLE;
            S_SEL_DR: state_d = tms ? S_SEL_IR : S_CAP_DR;
            S_CAP_DR: state_d = tms ? S_EX1_DR : S_SHF_DR;
            S_SHF_DR: state_d = tms ? S_EX1_DR : S_SHF_DR;
            S_EX1_DR: state_d = tms ? S_UPD_DR : S_PAU_DR;
            S_PAU_DR: state_d = tms ? S_EX2_DR : S_PAU_DR;
            S_EX2_DR: state_d = tms ? S_UPD_DR : S_SHF_DR;
            S_UPD_DR: state_d = tms ? S_SEL_DR : S_IDLE;
            S_SEL_IR: state_d = tms ? S_RESET  : S_CAP_IR;
            S_CAP_IR: state_d = tms ? S_EX1_IR : S_SHF_IR;
            S_SHF_IR: state_d = tms ? S_EX1_IR : S_SHF_IR;
            S_EX1_IR: state_d = tms ? S_UPD_IR : S_PAU_IR;
            S_PAU_IR: state_d = tms ? S_EX2_IR : S_PAU_IR;
            S_EX2_IR: state_d = tms ? S_UPD_IR : S_SHF_IR;
            S_UPD_IR: state_d = tms ? S_SEL_DR : S_IDLE;
        endcase
    end

    always_comb begin
        state    = state_q;
        in_reset = (state_q == S_RESET);
        cap_dr   = (state_q == S_CAP_DR);
        shf_dr   = (state_q == S_SHF_DR);
        upd_dr   = (state_q == S_UPD_DR);
        cap_ir   = (state_q == S_CAP_IR);
        shf_ir   = (state_q == S_SHF_IR);
        upd_ir   = (state_q == S_UPD_IR);
    end

endmodule

// File: rtl/jdp_ir.sv
module jdp_ir
    import jdp_pkg::*;
(
    input  logic     tck,
    input  logic     trst_n,
    input  logic     tdi,
    input  logic     in_reset,
    input  logic     cap_ir,
    input  logic     shf_ir,
    input  logic     upd_ir,
    output dr_kind_e kind,
    output logic     is_ap,
    output logic     ir_tdo
);

    logic [IR_W-1:0] ir_q;
    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_q  <= INS_IDCODE;
            ir_sr <= '0;
        end else if (in_reset) begin
            ir_q  <= INS_IDCODE;
        end else begin
            if (cap_ir)      ir_sr <= IR_CAPTURE;
            else if (shf_ir) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            if (upd_ir)      ir_q  <= ir_sr;
        end
    end

    always_comb begin
        kind  = K_BYPASS;
        is_ap = 1'b0;
        case (ir_q)
            INS_DPACC:  kind = K_ACCESS;
            INS_APACC:  begin kind = K_ACCESS; is_ap = 1'b1; end
            INS_IDCODE: kind = K_IDCODE;
            default:    kind = K_BYPASS;
        endcase
    end

    assign ir_tdo = ir_sr[0];

endmodule

// File: rtl/jdp_dr_path.sv
module jdp_dr_path
    import jdp_pkg::*;
#(
    parameter logic [DATA_W-1:0] IDCODE_VAL = 32'h3BA0_0477
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  logic              cap_dr,
    input  logic              shf_dr,
    input  dr_kind_e          kind,
    input  logic [DATA_W-1:0] ret_data,
    output logic [DR_W-1:0]   sr,
    output logic              dr_tdo
);

    logic [DR_W-1:0] sr_q, sr_shift;

    always_comb begin
        sr_shift = sr_q >> 1;
        unique case (kind)
            K_BYPASS: sr_shift[0]        = tdi;
            K_IDCODE: sr_shift[DATA_W-1] = tdi;
            K_ACCESS: sr_shift[DR_W-1]   = tdi;
            default:  sr_shift[0]        = tdi;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr_q <= '0;
        end else if (cap_dr) begin
            unique case (kind)
                K_IDCODE: sr_q <= {{ACK_W{1'b0}}, IDCODE_VAL};
                K_ACCESS: sr_q <= {ret_data, ACK_OK};
                default:  sr_q <= '0;
            endcase
        end else if (shf_dr) begin
            sr_q <= sr_shift;
        end
    end

    assign sr     = sr_q;
    assign dr_tdo = sr_q[0];

endmodule

// File: rtl/jdp_dp_regs.sv
module jdp_dp_regs
    import jdp_pkg::*;
(
    input  logic               tck,
    input  logic               trst_n,
    input  logic               upd,
    input  logic               is_ap,
    input  logic               rnw,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               rsp_valid,
    input  logic [DATA_W-1:0]  rsp_rdata,
    output logic               req_valid,
    output logic [ADDR_W-1:0]  req_addr,
    output logic               req_rnw,
    output logic [DATA_W-1:0]  req_wdata,
    output logic [APSEL_W-1:0] req_apsel,
    output logic [BANK_W-1:0]  req_bank,
    output logic [DATA_W-1:0]  ret_data
);

    logic [DATA_W-1:0] sel_q, rdbuf_q, ret_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sel_q     <= '0;
            rdbuf_q   <= '0;
            ret_q     <= '0;
            req_valid <= 1'b0;
            req_addr  <= '0;
            req_rnw   <= 1'b0;
            req_wdata <= '0;
        end else begin
            req_valid <= 1'b0;
            if (rsp_valid) begin
                rdbuf_q <= rsp_rdata;
                ret_q   <= rsp_rdata;
            end
            if (upd && is_ap) begin
                req_valid <= 1'b1;
                req_addr  <= addr;
                req_rnw   <= rnw;
                req_wdata <= wdata;
            end else if (upd) begin
                case (addr)
                    DPA_SELECT: if (rnw) ret_q <= sel_q; else sel_q <= wdata;
                    DPA_RDBUF:  if (rnw) ret_q <= rdbuf_q;
                    default:    if (rnw) ret_q <= '0;
                endcase
            end
        end
    end

    assign req_apsel = sel_q[APSEL_LSB +: APSEL_W];
    assign req_bank  = sel_q[BANK_LSB +: BANK_W];
    assign ret_data  = ret_q;

endmodule

// File: rtl/jtag_dp_scan.sv
module jtag_dp_scan
    import jdp_pkg::*;
#(
    parameter logic [31:0] IDCODE_VAL = 32'h3BA0_0477
) (
    input  logic        tck,
    input  logic        trst_n,
    input  logic        tms,
    input  logic        tdi,
    output logic        tdo,
    output logic        req_valid,
    output logic [1:0]  req_addr,
    output logic        req_rnw,
    output logic [31:0] req_wdata,
    output logic [7:0]  req_apsel,
    output logic [3:0]  req_bank,
    input  logic        rsp_valid,
    input  logic [31:0] rsp_rdata
);

    tap_state_e        tap_state;
    logic              in_reset, cap_dr, shf_dr, upd_dr, cap_ir, shf_ir, upd_ir;
    dr_kind_e          kind;
    logic              is_ap, ir_tdo, dr_tdo;
    logic [DR_W-1:0]   sr;
    logic [DATA_W-1:0] ret_data;

    jdp_tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(tap_state),
        .in_reset(in_reset), .cap_dr(cap_dr), .shf_dr(shf_dr), .upd_dr(upd_dr),
        .cap_ir(cap_ir), .shf_ir(shf_ir), .upd_ir(upd_ir)
    );

    jdp_ir u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .in_reset(in_reset),
        .cap_ir(cap_ir), .shf_ir(shf_ir), .upd_ir(upd_ir),
        .kind(kind), .is_ap(is_ap), .ir_tdo(ir_tdo)
    );

    jdp_dr_path #(.IDCODE_VAL(IDCODE_VAL)) u_dr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .cap_dr(cap_dr), .shf_dr(shf_dr),
        .kind(kind), .ret_data(ret_data), .sr(sr), .dr_tdo(dr_tdo)
    );

    jdp_dp_regs u_regs (
        .tck(tck), .trst_n(trst_n),
        .upd(upd_dr && (kind == K_ACCESS)), .is_ap(is_ap),
        .rnw(sr[0]), .addr(sr[ACK_W-1:1]), .wdata(sr[DR_W-1:ACK_W]),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_rnw(req_rnw),
        .req_wdata(req_wdata), .req_apsel(req_apsel), .req_bank(req_bank),
        .ret_data(ret_data)
    );

    always_comb begin
        unique case (1'b1)
            shf_dr:  tdo = dr_tdo;
            shf_ir:  tdo = ir_tdo;
            default: tdo = 1'b0;
        endcase
    end

endmodule

// File: rtl/jdp_checker.sv
module jdp_checker
    import jdp_pkg::*;
(
    input logic       tck,
    input logic       trst_n,
    input logic       tms,
    input logic       tdo,
    input tap_state_e state,
    input logic       req_valid,
    input logic [7:0] req_apsel,
    input logic [3:0] req_bank
);

    p_reset_hold_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (state == S_RESET && tms) |=> state == S_RESET);

    p_tdo_quiet_r11: assert property (@(posedge tck) disable iff (!trst_n)
        !(state == S_SHF_DR || state == S_SHF_IR) |-> !tdo);

    p_req_pulse_r6: assert property (@(posedge tck) disable iff (!trst_n)
        req_valid |=> !req_valid);

    p_req_from_update_r6: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(req_valid) |-> $past(state) == S_UPD_DR);

    p_select_stable_r8: assert property (@(posedge tck) disable iff (!trst_n)
        state != S_UPD_DR |=> ($stable(req_apsel) && $stable(req_bank)));

endmodule

bind jtag_dp_scan jdp_checker u_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdo(tdo), .state(tap_state),
    .req_valid(req_valid), .req_apsel(req_apsel), .req_bank(req_bank)
);

// File: tb/tb_jtag_dp_scan.sv
`timescale 1ns/1ps
module tb_jtag_dp_scan;

    localparam logic [31:0] IDV = 32'h3BA0_0477;

    logic        tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic        tdo, req_valid, req_rnw, rsp_valid = 1'b0;
    logic [1:0]  req_addr;
    logic [31:0] req_wdata, rsp_rdata = '0;
    logic [7:0]  req_apsel;
    logic [3:0]  req_bank;

    int total = 0, bad = 0;

    typedef struct packed {
        logic [1:0]  a;
        logic        rnw;
        logic [31:0] wd;
        logic [7:0]  ap;
        logic [3:0]  bk;
    } req_t;
    req_t exp_q[$];

    always #2.5 tck = ~tck;

    jtag_dp_scan #(.IDCODE_VAL(IDV)) dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .req_valid(req_valid), .req_addr(req_addr), .req_rnw(req_rnw),
        .req_wdata(req_wdata), .req_apsel(req_apsel), .req_bank(req_bank),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [31:0] rdm(logic [7:0] ap, logic [3:0] bk, logic [1:0] a);
        return {ap, bk, 4'h6, 12'h9D1, 2'b00, a};
    endfunction

    task automatic check(string req, logic [34:0] act, logic [34:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o);
        @(negedge tck);
        o   = tdo;
        tms = m;
        tdi = d;
    endtask

    task automatic tms_reset();
        logic o;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    task automatic scan_ir(input logic [3:0] din, output logic [3:0] dout);
        logic o;
        step(1'b1, 1'b0, o); step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, din[i], o);
            dout[i] = o;
        end
        step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
    endtask

    task automatic scan_dr(input int n, input logic [34:0] din, output logic [34:0] dout);
        logic o;
        dout = '0;
        step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o);
            dout[i] = o;
        end
        step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
    endtask

    // driver: pushes expected bus request for AP scans
    logic [7:0] m_ap = 8'h00;
    logic [3:0] m_bk = 4'h0;
    task automatic acc(input logic ap, input logic rnw, input logic [1:0] a,
                       input logic [31:0] wd, output logic [31:0] ret, output logic [2:0] ack);
        logic [34:0] d;
        if (ap) exp_q.push_back('{a: a, rnw: rnw, wd: wd, ap: m_ap, bk: m_bk});
        scan_dr(35, {wd, a, rnw}, d);
        ret = d[34:3];
        ack = d[2:0];
    endtask

    // responder
    initial forever begin
        @(posedge tck);
        rsp_valid <= req_valid && req_rnw;
        rsp_rdata <= rdm(req_apsel, req_bank, req_addr);
    end

    // monitor
    initial forever begin
        @(negedge tck);
        if (req_valid) begin
            req_t got;
            got = '{a: req_addr, rnw: req_rnw, wd: req_wdata, ap: req_apsel, bk: req_bank};
            if (exp_q.size() == 0) begin
                check("R8 unexpected bus request", {12'h0, got[46:24]}, 35'h0);
            end else begin
                req_t e;
                e = exp_q.pop_front();
                check("R6 bus request fields", {12'h0, got[46:24]}, {12'h0, e[46:24]});
                check("R6 select steering", {12'h0, got[22:0]}, {12'h0, e[22:0]});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge tck);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [34:0] d;
        logic [3:0]  irc;
        logic [31:0] r;
        logic [2:0]  k;
        logic        o;
        repeat (3) @(negedge tck);
        trst_n = 1'b1;
        @(negedge tck);
        check("R11 tdo in reset", {34'h0, tdo}, 35'h0);
        step(1'b0, 1'b0, o);

        scan_dr(32, '0, d);
        check("R3 idcode after trst", d, {3'b0, IDV});
        check("R3 idcode low bits", {23'h0, d[11:0]}, {23'h0, 12'h477});

        scan_ir(4'hF, irc);
        check("R2 ir capture", {31'h0, irc}, {31'h0, 4'b0001});
        scan_dr(8, {27'h0, 8'hA5}, d);
        check("R4 bypass delay", d, {27'h0, 8'h4A});
        scan_ir(4'h3, irc);
        scan_dr(8, {27'h0, 8'h3C}, d);
        check("R2 unassigned code is bypass", d, {27'h0, 8'h78});

        tms_reset();
        scan_dr(32, '0, d);
        check("R1 tms reset selects idcode", d, {3'b0, IDV});

        scan_ir(4'hA, irc);
        acc(1'b0, 1'b0, 2'd2, 32'h0300_0050, r, k);
        m_ap = 8'h03; m_bk = 4'h5;
        check("R5 ack OK", {32'h0, k}, {32'h0, 3'b010});
        check("R5 reset return data", {3'b0, r}, 35'h0);
        acc(1'b0, 1'b1, 2'd2, 32'h0, r, k);
        check("R10 dp write keeps return", {3'b0, r}, 35'h0);
        acc(1'b0, 1'b1, 2'd0, 32'h0, r, k);
        check("R8 select readback", {3'b0, r}, {3'b0, 32'h0300_0050});

        scan_ir(4'hB, irc);
        acc(1'b1, 1'b1, 2'd1, 32'h0, r, k);
        check("R10 dp addr0 reads zero", {3'b0, r}, 35'h0);
        acc(1'b1, 1'b1, 2'd3, 32'h0, r, k);
        check("R7 read data one scan later", {3'b0, r}, {3'b0, rdm(8'h03, 4'h5, 2'd1)});
        acc(1'b1, 1'b0, 2'd0, 32'hDEAD_BEEF, r, k);
        check("R7 second read returned", {3'b0, r}, {3'b0, rdm(8'h03, 4'h5, 2'd3)});
        check("R5 ack on ap scan", {32'h0, k}, {32'h0, 3'b010});

        scan_ir(4'hA, irc);
        acc(1'b0, 1'b1, 2'd0, 32'h0, r, k);
        check("R10 ap write keeps return", {3'b0, r}, {3'b0, rdm(8'h03, 4'h5, 2'd3)});
        acc(1'b0, 1'b1, 2'd3, 32'h0, r, k);
        check("R10 dp addr0 zero", {3'b0, r}, 35'h0);
        acc(1'b0, 1'b1, 2'd1, 32'h0, r, k);
        check("R9 read buffer", {3'b0, r}, {3'b0, rdm(8'h03, 4'h5, 2'd3)});
        acc(1'b0, 1'b0, 2'd2, 32'h0700_00C0, r, k);
        check("R10 dp addr1 zero", {3'b0, r}, 35'h0);
        m_ap = 8'h07; m_bk = 4'hC;

        scan_ir(4'hB, irc);
        acc(1'b1, 1'b1, 2'd2, 32'h0, r, k);
        check("R10 select write keeps return", {3'b0, r}, 35'h0);
        acc(1'b1, 1'b1, 2'd0, 32'h0, r, k);
        check("R8 new select steers", {3'b0, r}, {3'b0, rdm(8'h07, 4'hC, 2'd2)});

        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        check("R11 tdo in idle", {34'h0, o}, 35'h0);
        repeat (4) @(negedge tck);
        check("R6 all requests seen", exp_q.size(), 35'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule